// File: doc/BRIEF.md
# Block-Counted DMA Channel Controller

This block sequences a single DMA channel. Software sets three memory-mapped registers: a start address, a block descriptor that holds the words per block and the number of blocks, and a command register. Setting the run bit in the command register starts the channel. The controller then requests whole blocks from a peripheral-side port, one at a time. Each request carries the masked memory address, the block length in bytes and the transfer direction.

Each block the peripheral accepts moves the address forward by one block length and lowers the remaining count by one. When the count reaches zero, the run bit clears. A one-cycle interrupt pulse then goes out, tagged with a line index set by a parameter. That index does not depend on which channel this instance is. Moving the data, arbitrating between channels and collecting interrupts are all handled outside this block.

Top module: `dma_chan_ctrl`

## Requirements
- R1: After a synchronous reset, every register reads as zero, `blk_valid` is low and `irq_pulse` is low.
- R2: While the channel is running and the remaining count is nonzero, `blk_valid` stays high. Until the request is accepted, `blk_addr`, `blk_bytes` (words per block times 4) and `blk_dir` (command bit 0) hold steady.
- R3: `blk_addr` is the address register with bits 31:29 forced to zero.
- R4: Each accepted block (`blk_valid` and `blk_ready` high at a clock edge) lowers the count by one and adds words-per-block times 4 to the address register.
- R5: A command write (offset 0x8) with bit 24 set starts the channel. With bit 24 clear it stores the direction (bit 0) and mode (bit 9) bits, and no request follows.
- R6: A write at offset 0x4 loads words-per-block from bits 15:0 and the block count from bits 31:16. A write at offset 0x6 loads only the block count, from bits 15:0 of the write data.
- R7: A read at offset 0x0, 0x4 or 0x8 (relative to `BASE_ADDR`) returns that register on `rdata` one cycle after `rd_en`. In the command register only bits 0, 9 and 24 are non-zero. Any other offset, 0x6 included, reads as zero.
- R8: When the count is zero while the channel runs, bit 24 clears in the same edge that raises `irq_pulse` for exactly one cycle, with `irq_line` equal to `IRQ_LINE`. A channel started with a zero count finishes this way one cycle after the start.
- R9: While the channel runs, writes to the address, block and count offsets are ignored, and so is a command write with bit 24 set. A command write with bit 24 clear aborts the channel: only bit 24 clears, the other fields keep their values, and no interrupt pulse follows.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| blk_valid | output | 1 | Block request pending |
| blk_ready | input | 1 | Peripheral accepts the current block |
| blk_addr | output | 32 | Masked memory address of the block |
| blk_bytes | output | BS_W+2 | Block length in bytes |
| blk_dir | output | 1 | Transfer direction |
| irq_pulse | output | 1 | One-cycle completion pulse |
| irq_line | output | LINE_W | Interrupt line index, valid during the pulse |

## Verification
The bench sweeps block sizes of 1, 3 and 16 words against block counts of 0, 1, 2 and 5. Each size/count pair runs with the peripheral ready every cycle, every second cycle and every third cycle. Each run starts from an address whose top bits are set. The stall patterns show whether requests stay stable while they wait and are counted only on acceptance. The count sweep separates the immediate finish at zero from the single-block and multi-block cases. The top address bits show whether masking is applied to every block address. Separate sequences cover the upper-half count write, unmapped reads, a command write that does not start the channel, and writes made while the channel runs followed by an abort.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int OFS_ADDR  = 0;
  localparam int OFS_BLK   = 4;
  localparam int OFS_CNT   = 6;
  localparam int OFS_CMD   = 8;
  localparam int DIR_BIT   = 0;
  localparam int MODE_BIT  = 9;
  localparam int RUN_BIT   = 24;
  localparam logic [31:0] PHYS_MASK = 32'h1FFF_FFFF;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ADDR,
    SEL_BLK,
    SEL_CNT,
    SEL_CMD
  } reg_sel_e;
endpackage

// File: rtl/dma_chan_decode.sv
module dma_chan_decode
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h80
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr - BASE_ADDR;
    if (offset == ADDR_W'(OFS_ADDR))      sel = SEL_ADDR;
    else if (offset == ADDR_W'(OFS_BLK))  sel = SEL_BLK;
    else if (offset == ADDR_W'(OFS_CNT))  sel = SEL_CNT;
    else if (offset == ADDR_W'(OFS_CMD))  sel = SEL_CMD;
    else                                  sel = SEL_NONE;
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_pkg::*;
#(
  parameter int BS_W = 16,
  parameter int BA_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  reg_sel_e        sel,
  input  logic [31:0]     wdata,
  input  logic            blk_accept,
  input  logic            finish,
  output logic [31:0]     madr_q,
  output logic [BS_W-1:0] bs_q,
  output logic [BA_W-1:0] ba_q,
  output logic            dir_q,
  output logic            mode_q,
  output logic            run_q
);
  localparam int STEP_PAD = 32 - BS_W - 2;

  logic [31:0] step;
  logic        cmd_wr;

  assign step   = {{STEP_PAD{1'b0}}, bs_q, 2'b00};
  assign cmd_wr = wr_en && (sel == SEL_CMD);

  always_ff @(posedge clk) begin
    if (rst) begin
      madr_q <= '0;
      bs_q   <= '0;
      ba_q   <= '0;
      dir_q  <= 1'b0;
      mode_q <= 1'b0;
      run_q  <= 1'b0;
    end else if (run_q) begin
      if (finish) begin
        run_q <= 1'b0;
      end else begin
        if (blk_accept) begin
          ba_q   <= ba_q - 1'b1;
          madr_q <= madr_q + step;
        end
        if (cmd_wr && !wdata[RUN_BIT]) run_q <= 1'b0;
      end
    end else if (wr_en) begin
      case (sel)
        SEL_ADDR: madr_q <= wdata;
        SEL_BLK: begin
          bs_q <= wdata[BS_W-1:0];
          ba_q <= wdata[16 +: BA_W];
        end
        SEL_CNT: ba_q <= wdata[BA_W-1:0];
        SEL_CMD: begin
          dir_q  <= wdata[DIR_BIT];
          mode_q <= wdata[MODE_BIT];
          run_q  <= wdata[RUN_BIT];
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_chan_pkg::*;
#(
  parameter int BS_W     = 16,
  parameter int BA_W     = 16,
  parameter int LINE_W   = 5,
  parameter int IRQ_LINE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_q,
  input  logic [31:0]       madr_q,
  input  logic [BS_W-1:0]   bs_q,
  input  logic [BA_W-1:0]   ba_q,
  input  logic              dir_q,
  input  logic              blk_ready,
  output logic              blk_valid,
  output logic [31:0]       blk_addr,
  output logic [BS_W+1:0]   blk_bytes,
  output logic              blk_dir,
  output logic              blk_accept,
  output logic              finish,
  output logic              irq_pulse,
  output logic [LINE_W-1:0] irq_line
);
  logic cnt_zero;

  assign cnt_zero   = (ba_q == '0);
  assign blk_valid  = run_q && !cnt_zero;
  assign finish     = run_q && cnt_zero;
  assign blk_accept = blk_valid && blk_ready;
  assign blk_addr   = madr_q & PHYS_MASK;
  assign blk_bytes  = {bs_q, 2'b00};
  assign blk_dir    = dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_pulse <= 1'b0;
      irq_line  <= '0;
    end else begin
      irq_pulse <= finish;
      irq_line  <= finish ? LINE_W'(IRQ_LINE) : '0;
    end
  end
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h80,
  parameter int BS_W     = 16,
  parameter int BA_W     = 16,
  parameter int LINE_W   = 5,
  parameter int IRQ_LINE = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              blk_valid,
  input  logic              blk_ready,
  output logic [31:0]       blk_addr,
  output logic [BS_W+1:0]   blk_bytes,
  output logic              blk_dir,
  output logic              irq_pulse,
  output logic [LINE_W-1:0] irq_line
);
  localparam int BA_PAD = 16 - BA_W;

  reg_sel_e        sel;
  logic [31:0]     madr_q;
  logic [BS_W-1:0] bs_q;
  logic [BA_W-1:0] ba_q;
  logic            dir_q, mode_q, run_q;
  logic            blk_accept, finish;
  logic [31:0]     rd_mux;

  dma_chan_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(addr), .sel(sel)
  );

  dma_chan_regs #(.BS_W(BS_W), .BA_W(BA_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wdata(wdata),
    .blk_accept(blk_accept), .finish(finish),
    .madr_q(madr_q), .bs_q(bs_q), .ba_q(ba_q),
    .dir_q(dir_q), .mode_q(mode_q), .run_q(run_q)
  );

  dma_chan_seq #(.BS_W(BS_W), .BA_W(BA_W), .LINE_W(LINE_W), .IRQ_LINE(IRQ_LINE)) u_seq (
    .clk(clk), .rst(rst), .run_q(run_q), .madr_q(madr_q), .bs_q(bs_q),
    .ba_q(ba_q), .dir_q(dir_q), .blk_ready(blk_ready),
    .blk_valid(blk_valid), .blk_addr(blk_addr), .blk_bytes(blk_bytes),
    .blk_dir(blk_dir), .blk_accept(blk_accept), .finish(finish),
    .irq_pulse(irq_pulse), .irq_line(irq_line)
  );

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_ADDR: rd_mux = madr_q;
      SEL_BLK:  rd_mux = {{BA_PAD{1'b0}}, ba_q, {(16-BS_W){1'b0}}, bs_q};
      SEL_CMD: begin
        rd_mux[DIR_BIT]  = dir_q;
        rd_mux[MODE_BIT] = mode_q;
        rd_mux[RUN_BIT]  = run_q;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/dma_chan_ctrl_chk.sv
module dma_chan_ctrl_chk #(
  parameter int BS_W     = 16,
  parameter int LINE_W   = 5,
  parameter int IRQ_LINE = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              blk_valid,
  input logic              blk_ready,
  input logic [31:0]       blk_addr,
  input logic [BS_W+1:0]   blk_bytes,
  input logic              blk_dir,
  input logic              irq_pulse,
  input logic [LINE_W-1:0] irq_line,
  input logic              busy
);
  // R2: a waiting request holds its content
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && !blk_ready && !wr_en) |=>
      (blk_valid && $stable(blk_addr) && $stable(blk_bytes) && $stable(blk_dir)));

  // R3: top address bits never reach the port
  p_mask_r3: assert property (@(posedge clk) disable iff (rst)
    blk_valid |-> (blk_addr[31:29] == 3'b000));

  // R4: an accepted block moves the next request by one block length
  p_advance_r4: assert property (@(posedge clk) disable iff (rst)
    (blk_valid && blk_ready) |=>
      (!blk_valid || blk_addr == (($past(blk_addr) + 32'($past(blk_bytes))) & 32'h1FFF_FFFF)));

  // R8: pulse lasts one cycle, follows a running channel, carries the line
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |=> !irq_pulse);
  p_pulse_after_run_r8: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> ($past(busy) && !busy && !blk_valid));
  p_pulse_line_r8: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> (irq_line == LINE_W'(IRQ_LINE)));
endmodule

bind dma_chan_ctrl dma_chan_ctrl_chk #(.BS_W(BS_W), .LINE_W(LINE_W), .IRQ_LINE(IRQ_LINE)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .blk_valid(blk_valid), .blk_ready(blk_ready),
  .blk_addr(blk_addr), .blk_bytes(blk_bytes), .blk_dir(blk_dir),
  .irq_pulse(irq_pulse), .irq_line(irq_line), .busy(run_q)
);

// File: tb/test_dma_chan_ctrl.sv
module test_dma_chan_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int LINE       = 9;
  localparam logic [7:0] BASE = 8'h80;

  logic        clk = 1'b0;
  logic        rst, wr_en, rd_en, blk_ready;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata, blk_addr;
  logic        blk_valid, blk_dir, irq_pulse;
  logic [17:0] blk_bytes;
  logic [4:0]  irq_line;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_chan_ctrl #(.ADDR_W(8), .BASE_ADDR(BASE), .LINE_W(5), .IRQ_LINE(LINE)) i_dma_chan_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .blk_valid(blk_valid), .blk_ready(blk_ready), .blk_addr(blk_addr),
    .blk_bytes(blk_bytes), .blk_dir(blk_dir), .irq_pulse(irq_pulse), .irq_line(irq_line)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] ofs, input logic [31:0] d);
    @(negedge clk);
    addr = BASE + ofs; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] ofs, output logic [31:0] d);
    @(negedge clk);
    addr = BASE + ofs; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic run_xfer(input logic [31:0] start, input int bs, input int ba,
                          input bit dir, input int pat);
    logic [31:0] exp_addr, v;
    int nblk = 0;
    int nirq = 0;
    int tail = 0;
    exp_addr = start;
    wr(8'h0, start);
    wr(8'h4, {ba[15:0], bs[15:0]});
    wr(8'h8, 32'h0100_0200 | {31'b0, dir});
    for (int k = 0; k < 400 && tail < 4; k++) begin
      blk_ready = ((k % pat) == 0);
      if (blk_valid) begin
        chk(blk_addr == (exp_addr & 32'h1FFF_FFFF), "R2/R3 block address", blk_addr, exp_addr & 32'h1FFF_FFFF);
        chk(blk_bytes == 18'(bs * 4), "R2 block bytes", 32'(blk_bytes), 32'(bs * 4));
        chk(blk_dir == dir, "R2 direction", 32'(blk_dir), 32'(dir));
        if (blk_ready) begin
          nblk++;
          exp_addr = exp_addr + 32'(bs * 4);
        end
      end
      if (irq_pulse) begin
        nirq++;
        chk(irq_line == 5'(LINE), "R8 irq line", 32'(irq_line), LINE);
      end
      if (nirq > 0) tail++;
      @(negedge clk);
    end
    blk_ready = 1'b0;
    chk(nblk == ba, "R4 accepted blocks", nblk, ba);
    chk(nirq == 1, "R8 one irq pulse", nirq, 1);
    rd(8'h0, v); chk(v == exp_addr, "R4 final address", v, exp_addr);
    rd(8'h4, v); chk(v == {16'h0, bs[15:0]}, "R4 count drained", v, {16'h0, bs[15:0]});
    rd(8'h8, v); chk(v == (32'h200 | dir), "R8 run bit cleared", v, 32'h200 | dir);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int idle_irq;
    int sizes[3] = '{1, 3, 16};
    int counts[4] = '{0, 1, 2, 5};
    rst = 1'b1; wr_en = 0; rd_en = 0; blk_ready = 0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk(!blk_valid && !irq_pulse, "R1 outputs idle", {30'b0, blk_valid, irq_pulse}, 0);
    rd(8'h0, v); chk(v == 0, "R1 address reg", v, 0);
    rd(8'h4, v); chk(v == 0, "R1 block reg", v, 0);
    rd(8'h8, v); chk(v == 0, "R1 command reg", v, 0);

    // R2 R3 R4 R8 sweep
    for (int s = 0; s < 3; s++)
      for (int c = 0; c < 4; c++)
        for (int p = 1; p <= 3; p++)
          run_xfer(32'hE000_0100 + 32'(s * 64 + p * 4), sizes[s], counts[c], bit'((c + p) % 2), p);

    // R6 half write updates count only
    wr(8'h4, 32'h0007_0009);
    wr(8'h6, 32'hABCD_0004);
    rd(8'h4, v); chk(v == 32'h0004_0009, "R6 upper half write", v, 32'h0004_0009);

    // R7 unmapped reads
    rd(8'h6, v); chk(v == 0, "R7 read at 0x6", v, 0);
    rd(8'hC, v); chk(v == 0, "R7 read at 0xC", v, 0);
    rd(8'hF0, v); chk(v == 0, "R7 read below base", v, 0);

    // R5 command without run bit
    wr(8'h8, 32'hFEFF_FFFF);
    rd(8'h8, v); chk(v == 32'h0000_0201, "R5 stored mode and direction", v, 32'h201);
    repeat (3) @(negedge clk);
    chk(!blk_valid, "R5 no request without run bit", 32'(blk_valid), 0);

    // R9 writes while running, then abort
    wr(8'h0, 32'h0000_1000);
    wr(8'h4, 32'h0003_0002);
    wr(8'h8, 32'h0100_0201);
    wr(8'h0, 32'h5555_5555);
    wr(8'h4, 32'h0009_0009);
    wr(8'h6, 32'h0000_0001);
    wr(8'h8, 32'h0100_0000);
    rd(8'h0, v); chk(v == 32'h1000, "R9 address write ignored", v, 32'h1000);
    rd(8'h4, v); chk(v == 32'h0003_0002, "R9 block writes ignored", v, 32'h0003_0002);
    rd(8'h8, v); chk(v == 32'h0100_0201, "R9 command write ignored", v, 32'h0100_0201);
    chk(blk_valid && blk_addr == 32'h1000, "R9 request unchanged", blk_addr, 32'h1000);
    @(negedge clk);
    addr = BASE + 8'h8; wdata = 32'h0; wr_en = 1'b1;
    idle_irq = 0;
    @(negedge clk);
    wr_en = 1'b0;
    if (irq_pulse) idle_irq++;
    chk(!blk_valid, "R9 abort drops request", 32'(blk_valid), 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (irq_pulse) idle_irq++;
    end
    chk(idle_irq == 0, "R9 abort raises no irq", idle_irq, 0);
    rd(8'h8, v); chk(v == 32'h0000_0201, "R9 abort keeps fields", v, 32'h201);
    rd(8'h4, v); chk(v == 32'h0003_0002, "R9 abort keeps count", v, 32'h0003_0002);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule